// File: doc/BRIEF.md
# Channel Limit Monitor with Sticky Flags and Alert

This block watches a stream of measurement results, one per cycle at most, each tagged with the channel it belongs to. It compares every result against that channel's programmable high and low thresholds. It keeps the outcome in two sets of flags. The first set is the live condition from the channel's latest result. The second set is sticky status flags that software reads.

Each set status flag that is not masked pulls an active-low alert line. Reading a status byte clears only the flags whose condition has gone away. A completed alert-response handshake clears every flag and releases the alert. If the fault is still there, the next violating result drives the alert again.

The status bytes are laid out as follows. In the high-flag byte and the low-flag byte, bit i belongs to channel i. A third byte carries the alert state in bit 0.

Top module: `lmon_top`

## Requirements
- R1: A result on channel c sets high-flag bit c when the value is greater than or equal to that channel's high threshold (the comparison is inclusive).
- R2: A result on channel c sets low-flag bit c when the value is strictly below that channel's low threshold (equal does not set it).
- R3: A set flag stays set after later in-limit results and after reads of the other status bytes.
- R4: A read with select 0 clears only the high flags whose channel's latest result was in limit. A read with select 1 does the same for the low flags. Flags whose condition is still active stay set. A read with select 2 clears nothing.
- R5: A flag that is being set in the same cycle as a clearing read or an alert-response completion ends that cycle set.
- R6: An alert-response completion clears all status flags and releases the alert. A later violating result asserts the alert again.
- R7: `alert_n_o` is low exactly when some status flag is set and its mask bit is 0. A masked source still sets its status flag.
- R8: Bit 0 of `sts_ext_o` is 1 exactly when the alert is driven low. Bits 7:1 of `sts_ext_o` are 0.
- R9: A result whose channel index is NUM_CH or higher changes no flag.
- R10: After reset all flags are 0 and the alert is released (high).

Code values: for `st_sel_i`, 0 selects the high flags, 1 the low flags and 2 the extended byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld_i | input | 1 | A new result is present this cycle |
| res_ch_i | input | CH_W | Channel of the result |
| res_val_i | input | DW | Result value (unsigned) |
| lim_hi_i | input | NUM_CH*DW | High thresholds, channel i at bits i*DW +: DW |
| lim_lo_i | input | NUM_CH*DW | Low thresholds, same packing |
| mask_hi_i | input | NUM_CH | 1 keeps the high flag of channel i off the alert |
| mask_lo_i | input | NUM_CH | 1 keeps the low flag of channel i off the alert |
| st_rd_i | input | 1 | Status read strobe |
| st_sel_i | input | 2 | Status byte selected by the read |
| ara_done_i | input | 1 | Alert-response handshake completed |
| sts_hi_o | output | NUM_CH | Sticky high flags |
| sts_lo_o | output | NUM_CH | Sticky low flags |
| sts_ext_o | output | 8 | Extended status, bit 0 = alert active |
| alert_n_o | output | 1 | Active-low alert, high when released |

## Verification
The hardest case to reach is a clearing read or an alert-response strobe that falls on the same edge as a new violating result. Only that case shows whether set wins over clear. The bench drives the result strobe and the read or acknowledge strobe from one task in the same cycle, and the channel's live condition is cleared beforehand. A related hard case is a read made while a condition is still active. The bench reaches it by leaving a violating result as the channel's latest one, then following it with a clean result and a second read.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
    localparam logic [1:0] SEL_HI  = 2'd0;
    localparam logic [1:0] SEL_LO  = 2'd1;
    localparam logic [1:0] SEL_EXT = 2'd2;
    localparam int         EXT_W   = 8;
endpackage

// File: rtl/lmon_cmp.sv
module lmon_cmp #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int CH_W   = 2
) (
    input  logic                 res_vld_i,
    input  logic [CH_W-1:0]      res_ch_i,
    input  logic [DW-1:0]        res_val_i,
    input  logic [NUM_CH*DW-1:0] lim_hi_i,
    input  logic [NUM_CH*DW-1:0] lim_lo_i,
    output logic [NUM_CH-1:0]    upd_o,
    output logic [NUM_CH-1:0]    hi_hit_o,
    output logic [NUM_CH-1:0]    lo_hit_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // a channel index outside 0..NUM_CH-1 matches no slice
        assign upd_o[g]    = res_vld_i && (res_ch_i == CH_W'(g));
        assign hi_hit_o[g] = res_val_i >= lim_hi_i[g*DW +: DW];
        assign lo_hit_o[g] = res_val_i <  lim_lo_i[g*DW +: DW];
    end
endmodule

// File: rtl/lmon_stat.sv
module lmon_stat
    import lmon_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] upd_i,
    input  logic [NUM_CH-1:0] hi_hit_i,
    input  logic [NUM_CH-1:0] lo_hit_i,
    input  logic              rd_i,
    input  logic [1:0]        sel_i,
    input  logic              ara_i,
    output logic [NUM_CH-1:0] st_hi_o,
    output logic [NUM_CH-1:0] st_lo_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] live_hi;
        logic [NUM_CH-1:0] live_lo;
        logic [NUM_CH-1:0] st_hi;
        logic [NUM_CH-1:0] st_lo;
    } stat_t;

    stat_t             s_d, s_q;
    logic [NUM_CH-1:0] set_hi, set_lo, clr_hi, clr_lo;

    always_comb begin
        s_d    = s_q;
        set_hi = upd_i & hi_hit_i;
        set_lo = upd_i & lo_hit_i;
        clr_hi = '0;
        clr_lo = '0;
        if (ara_i) begin
            clr_hi = '1;
            clr_lo = '1;
        end else if (rd_i && sel_i == SEL_HI) begin
            clr_hi = ~s_q.live_hi;
        end else if (rd_i && sel_i == SEL_LO) begin
            clr_lo = ~s_q.live_lo;
        end
        // live condition follows the latest result of each channel
        s_d.live_hi = (s_q.live_hi & ~upd_i) | set_hi;
        s_d.live_lo = (s_q.live_lo & ~upd_i) | set_lo;
        // setting has priority over clearing
        s_d.st_hi   = (s_q.st_hi & ~clr_hi) | set_hi;
        s_d.st_lo   = (s_q.st_lo & ~clr_lo) | set_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_hi_o = s_q.st_hi;
    assign st_lo_o = s_q.st_lo;
endmodule

// File: rtl/lmon_alert.sv
module lmon_alert
    import lmon_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] st_hi_i,
    input  logic [NUM_CH-1:0] st_lo_i,
    input  logic [NUM_CH-1:0] mask_hi_i,
    input  logic [NUM_CH-1:0] mask_lo_i,
    output logic              alert_n_o,
    output logic [EXT_W-1:0]  ext_o
);
    logic pull;

    always_comb begin
        pull      = |((st_hi_i & ~mask_hi_i) | (st_lo_i & ~mask_lo_i));
        alert_n_o = ~pull;
        ext_o     = {{(EXT_W-1){1'b0}}, pull};
    end
endmodule

// File: rtl/lmon_top.sv
module lmon_top
    import lmon_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_vld_i,
    input  logic [CH_W-1:0]      res_ch_i,
    input  logic [DW-1:0]        res_val_i,
    input  logic [NUM_CH*DW-1:0] lim_hi_i,
    input  logic [NUM_CH*DW-1:0] lim_lo_i,
    input  logic [NUM_CH-1:0]    mask_hi_i,
    input  logic [NUM_CH-1:0]    mask_lo_i,
    input  logic                 st_rd_i,
    input  logic [1:0]           st_sel_i,
    input  logic                 ara_done_i,
    output logic [NUM_CH-1:0]    sts_hi_o,
    output logic [NUM_CH-1:0]    sts_lo_o,
    output logic [EXT_W-1:0]     sts_ext_o,
    output logic                 alert_n_o
);
    logic [NUM_CH-1:0] upd_w, hi_hit_w, lo_hit_w;

    lmon_cmp #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) cmp_i (
        .res_vld_i (res_vld_i),
        .res_ch_i  (res_ch_i),
        .res_val_i (res_val_i),
        .lim_hi_i  (lim_hi_i),
        .lim_lo_i  (lim_lo_i),
        .upd_o     (upd_w),
        .hi_hit_o  (hi_hit_w),
        .lo_hit_o  (lo_hit_w)
    );

    lmon_stat #(.NUM_CH(NUM_CH)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd_w),
        .hi_hit_i (hi_hit_w),
        .lo_hit_i (lo_hit_w),
        .rd_i     (st_rd_i),
        .sel_i    (st_sel_i),
        .ara_i    (ara_done_i),
        .st_hi_o  (sts_hi_o),
        .st_lo_o  (sts_lo_o)
    );

    lmon_alert #(.NUM_CH(NUM_CH)) alert_i (
        .st_hi_i   (sts_hi_o),
        .st_lo_i   (sts_lo_o),
        .mask_hi_i (mask_hi_i),
        .mask_lo_i (mask_lo_i),
        .alert_n_o (alert_n_o),
        .ext_o     (sts_ext_o)
    );
endmodule

// File: rtl/lmon_chk.sv
module lmon_chk #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int CH_W   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 res_vld_i,
    input logic [CH_W-1:0]      res_ch_i,
    input logic [DW-1:0]        res_val_i,
    input logic [NUM_CH*DW-1:0] lim_hi_i,
    input logic [NUM_CH*DW-1:0] lim_lo_i,
    input logic [NUM_CH-1:0]    mask_hi_i,
    input logic [NUM_CH-1:0]    mask_lo_i,
    input logic                 st_rd_i,
    input logic [1:0]           st_sel_i,
    input logic                 ara_done_i,
    input logic [NUM_CH-1:0]    sts_hi_o,
    input logic [NUM_CH-1:0]    sts_lo_o,
    input logic [7:0]           sts_ext_o,
    input logic                 alert_n_o
);
    p_hi_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_i && (int'(res_ch_i) < NUM_CH) &&
         res_val_i >= lim_hi_i[res_ch_i*DW +: DW])
        |=> sts_hi_o[$past(res_ch_i)]);

    p_lo_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_i && (int'(res_ch_i) < NUM_CH) &&
         res_val_i < lim_lo_i[res_ch_i*DW +: DW])
        |=> sts_lo_o[$past(res_ch_i)]);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ara_done_i && !st_rd_i)
        |=> ((sts_hi_o & $past(sts_hi_o)) == $past(sts_hi_o)) &&
            ((sts_lo_o & $past(sts_lo_o)) == $past(sts_lo_o)));

    p_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_i |=> ((sts_hi_o & ~$past(sts_hi_o)) == '0) &&
                       ((sts_lo_o & ~$past(sts_lo_o)) == '0));

    p_ara_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_done_i && !res_vld_i)
        |=> (sts_hi_o == '0) && (sts_lo_o == '0) && alert_n_o);

    p_quiet_alert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((sts_hi_o & ~mask_hi_i) == '0) && ((sts_lo_o & ~mask_lo_i) == '0))
        |-> alert_n_o);

    p_ext_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ext_o[7:1] == 7'd0) && (sts_ext_o[0] != alert_n_o));
endmodule

bind lmon_top lmon_chk #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) chk_i (.*);

// File: tb/lmon_top_tb_top.sv
`timescale 1ns/1ps
module lmon_top_tb_top;
    localparam int NCH = 3;
    localparam int DW  = 8;
    localparam int CHW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_vld = 1'b0;
    logic [CHW-1:0] res_ch = '0;
    logic [DW-1:0]  res_val = '0;
    logic [NCH*DW-1:0] lim_hi = {8'd255, 8'd200, 8'd100};
    logic [NCH*DW-1:0] lim_lo = {8'd0, 8'd10, 8'd40};
    logic [NCH-1:0] mask_hi = '0, mask_lo = '0;
    logic st_rd = 1'b0;
    logic [1:0] st_sel = '0;
    logic ara = 1'b0;
    logic [NCH-1:0] sts_hi, sts_lo;
    logic [7:0] sts_ext;
    logic alert_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lmon_top #(.NUM_CH(NCH), .DW(DW), .CH_W(CHW)) dut_i (
        .clk(clk), .rst_n(rst_n), .res_vld_i(res_vld), .res_ch_i(res_ch),
        .res_val_i(res_val), .lim_hi_i(lim_hi), .lim_lo_i(lim_lo),
        .mask_hi_i(mask_hi), .mask_lo_i(mask_lo), .st_rd_i(st_rd),
        .st_sel_i(st_sel), .ara_done_i(ara), .sts_hi_o(sts_hi),
        .sts_lo_o(sts_lo), .sts_ext_o(sts_ext), .alert_n_o(alert_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs are checked at the following negedge
    task automatic cyc(input logic v, input int ch, input int val,
                       input logic rd, input int sel, input logic a);
        @(negedge clk);
        res_vld = v; res_ch = CHW'(ch); res_val = DW'(val);
        st_rd = rd; st_sel = 2'(sel); ara = a;
        @(negedge clk);
        res_vld = 1'b0; st_rd = 1'b0; ara = 1'b0;
    endtask

    task automatic send(input int ch, input int val);
        cyc(1'b1, ch, val, 1'b0, 0, 1'b0);
    endtask

    task automatic rd(input int sel);
        cyc(1'b0, 0, 0, 1'b1, sel, 1'b0);
    endtask

    task automatic ack();
        cyc(1'b0, 0, 0, 1'b0, 0, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 hi", int'(sts_hi), 0);
        chk("R10 lo", int'(sts_lo), 0);
        chk("R10 alert", int'(alert_n), 1);
        rst_n = 1'b1;

        // R1/R2 sweep every channel over all values
        for (int ch = 0; ch < NCH; ch++) begin
            for (int v = 0; v < 256; v++) begin
                int eh, el;
                ack();
                send(ch, v);
                eh = (v >= int'(lim_hi[ch*DW +: DW])) ? (1 << ch) : 0;
                el = (v <  int'(lim_lo[ch*DW +: DW])) ? (1 << ch) : 0;
                chk("R1 hi sweep", int'(sts_hi), eh);
                chk("R2 lo sweep", int'(sts_lo), el);
                chk("R7 alert sweep", int'(alert_n), (eh | el) != 0 ? 0 : 1);
                chk("R8 ext sweep", int'(sts_ext), (eh | el) != 0 ? 1 : 0);
            end
        end

        // R3 sticky across clean results and other reads
        ack();
        send(0, 150);
        send(0, 70);
        rd(1); rd(2);
        chk("R3 sticky", int'(sts_hi), 1);
        // R4 read with condition still active keeps the flag
        send(0, 120);
        rd(0);
        chk("R4 active kept", int'(sts_hi), 1);
        send(0, 70);
        rd(1);
        chk("R4 wrong select", int'(sts_hi), 1);
        rd(2);
        chk("R4 ext select", int'(sts_hi), 1);
        rd(0);
        chk("R4 inactive cleared", int'(sts_hi), 0);
        chk("R7 released", int'(alert_n), 1);
        // R4 low flags, mixed active and inactive
        send(0, 5); send(1, 5); send(0, 70);
        rd(1);
        chk("R4 lo partial", int'(sts_lo), 2);

        // R5 set wins over a clearing read and over ack
        ack();
        send(2, 9);
        cyc(1'b1, 2, 255, 1'b1, 0, 1'b0);
        chk("R5 set vs read", int'(sts_hi), 4);
        cyc(1'b1, 1, 0, 1'b0, 0, 1'b1);
        chk("R5 set vs ack lo", int'(sts_lo), 2);
        chk("R5 ack clears hi", int'(sts_hi), 0);

        // R6 ack releases, persistent fault reasserts on next result
        ack();
        send(1, 220);
        chk("R6 asserted", int'(alert_n), 0);
        ack();
        chk("R6 released", int'(alert_n), 1);
        chk("R6 cleared", int'(sts_hi), 0);
        send(1, 230);
        chk("R6 reasserted", int'(alert_n), 0);

        // R7 masking
        ack();
        mask_hi = 3'b001;
        send(0, 200);
        chk("R7 masked sets flag", int'(sts_hi), 1);
        chk("R7 masked no alert", int'(alert_n), 1);
        chk("R8 ext masked", int'(sts_ext), 0);
        mask_hi = 3'b000;
        @(negedge clk);
        chk("R7 unmasked alert", int'(alert_n), 0);
        mask_lo = 3'b010;
        ack();
        send(1, 3);
        chk("R7 lo masked", int'(alert_n), 1);
        chk("R7 lo flag", int'(sts_lo), 2);
        mask_lo = 3'b000;

        // R9 out-of-range channel ignored
        ack();
        send(3, 255);
        send(3, 0);
        chk("R9 hi", int'(sts_hi), 0);
        chk("R9 lo", int'(sts_lo), 0);
        chk("R9 alert", int'(alert_n), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule